// File: doc/BRIEF.md
# Register Window Index Translator

This block turns an architectural integer register number into an index into a physical register file. The physical file holds several banks of global registers, a circular store of overlapping register windows, and a small group of microcode scratch registers. A current window pointer and a global level are kept in the block. Together they decide which physical entry each architectural name reaches.

Every lookup also carries a view select. The view picks the current window or one of its two neighbours. Save and restore sequences use the neighbour views to reach the window they are about to enter while the pointer still holds the old value. The window pointer and the global level each have their own write port. The physical index comes out registered, one clock after the lookup is presented.

Top module: `rwt_translator`

## Requirements
- R1: A synchronous active-high reset clears the window pointer, the global level and the registered physical index to zero. After reset, lookups behave as with pointer 0 and level 0.
- R2: Architectural index 0 always yields physical index 0, whatever the global level and view.
- R3: Architectural index g, with 1 <= g < GLOB, yields g + level * GLOB in every view.
- R4: Architectural index a in the windowed range (GLOB <= a < GLOB + 1.5*RPW) has slot s = a - GLOB. In view code 0 (current) it yields TG + ((s - ptr*RPW) mod TW), where TG = GLOB*NUM_GL and TW = NWIN*RPW.
- R5: View code 1 (next) uses window (ptr - 1) mod NWIN, so pointer 0 reaches window NWIN-1. View code 2 (previous) uses window (ptr + 1) mod NWIN. View code 3 acts as code 0.
- R6: A pointer write with a value of NWIN or more stores NWIN-1. A smaller value is stored unchanged.
- R7: A level write stores the written value. Pointer and level keep their values in cycles without a write to them.
- R8: Architectural index MB + k, where MB = GLOB + 1.5*RPW and 0 <= k < NUM_MICRO, yields k + TG + TW.
- R9: Architectural indices at or above MB + NUM_MICRO yield physical index 0.
- R10: The physical index for a lookup presented in cycle n appears after the clock edge that ends cycle n. A write in cycle n affects lookups presented in cycle n+1 and later, and does not affect the lookup presented in cycle n itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cwp_we | input | 1 | Window pointer write enable |
| cwp_wdata | input | CWP_WR_W | Window pointer write value, clamped to NWIN-1 |
| gl_we | input | 1 | Global level write enable |
| gl_wdata | input | GL_W | Global level write value |
| arch_idx | input | ARCH_W | Architectural register number |
| view_sel | input | 2 | 0 current, 1 next, 2 previous, 3 current |
| phys_idx | output | PHYS_W | Registered physical register index |

## Verification
The bench builds the block with four windows of sixteen registers, eight globals per set, two global levels and four microcode registers. This keeps the architectural space at 64 codes and the pointer write port at 4 bits. It can therefore sweep every pointer write value, including all twelve that must saturate, against both levels, all four view codes and every architectural code. With four windows, the wrap of the next view from window 0 and of the previous view from window 3 shows up in a few cycles, and so does the overlap of the last windowed slots into the neighbouring window's storage.

// File: rtl/rwt_pkg.sv
package rwt_pkg;

  // View codes presented with each lookup.
  typedef enum logic [1:0] {
    VIEW_CUR  = 2'd0,
    VIEW_NEXT = 2'd1,
    VIEW_PREV = 2'd2,
    VIEW_ALT  = 2'd3
  } view_e;

  // Class of an architectural register number.
  typedef enum logic [1:0] {
    KIND_GLOB  = 2'd0,
    KIND_WIN   = 2'd1,
    KIND_MICRO = 2'd2,
    KIND_BAD   = 2'd3
  } kind_e;

  localparam int NUM_VIEWS = 3;

endpackage

// File: rtl/rwt_state.sv
// Window pointer and global level registers. Pointer writes saturate.
module rwt_state #(
  parameter int NWIN     = 8,
  parameter int NUM_GL   = 4,
  parameter int CWP_WR_W = 5,
  localparam int WIN_W   = $clog2(NWIN),
  localparam int GL_W    = (NUM_GL > 1) ? $clog2(NUM_GL) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cwp_we,
  input  logic [CWP_WR_W-1:0] cwp_wdata,
  input  logic                gl_we,
  input  logic [GL_W-1:0]     gl_wdata,
  output logic [WIN_W-1:0]    cwp_q,
  output logic [GL_W-1:0]     gl_q
);

  localparam logic [WIN_W-1:0] TOP_WIN = WIN_W'(NWIN - 1);

  logic [WIN_W-1:0] cwp_clamped;

  always_comb begin
    if (int'(cwp_wdata) >= NWIN) cwp_clamped = TOP_WIN;
    else                         cwp_clamped = cwp_wdata[WIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q <= '0;
      gl_q  <= '0;
    end else begin
      if (cwp_we) cwp_q <= cwp_clamped;
      if (gl_we)  gl_q  <= gl_wdata;
    end
  end

endmodule

// File: rtl/rwt_win_map.sv
// Offset of a windowed slot inside the circular window store for one window.
module rwt_win_map #(
  parameter int NWIN      = 8,
  parameter int RPW       = 16,
  localparam int WIN_W    = $clog2(NWIN),
  localparam int WIN_SLOTS = RPW + RPW / 2,
  localparam int SLOT_W   = $clog2(WIN_SLOTS),
  localparam int OFF_W    = $clog2(NWIN * RPW)
) (
  input  logic [WIN_W-1:0]  win,
  input  logic [SLOT_W-1:0] slot,
  output logic [OFF_W-1:0]  offset
);

  // Truncation to OFF_W bits is the modulo over the power-of-two store size.
  logic [OFF_W-1:0] base;

  always_comb begin
    base   = OFF_W'(win) * OFF_W'(RPW);
    offset = OFF_W'(slot) - base;
  end

endmodule

// File: rtl/rwt_glob_map.sv
// Banked global registers; slot 0 is pinned to physical entry 0.
module rwt_glob_map #(
  parameter int GLOB     = 8,
  parameter int NUM_GL   = 4,
  parameter int PHYS_W   = 8,
  localparam int G_W     = $clog2(GLOB),
  localparam int GL_W    = (NUM_GL > 1) ? $clog2(NUM_GL) : 1
) (
  input  logic [GL_W-1:0]   gl,
  input  logic [G_W-1:0]    gslot,
  output logic [PHYS_W-1:0] phys
);

  always_comb begin
    if (gslot == '0) phys = '0;
    else             phys = PHYS_W'(gslot) + PHYS_W'(gl) * PHYS_W'(GLOB);
  end

endmodule

// File: rtl/rwt_translator.sv
module rwt_translator
  import rwt_pkg::*;
#(
  parameter int NWIN       = 8,
  parameter int RPW        = 16,
  parameter int GLOB       = 8,
  parameter int NUM_GL     = 4,
  parameter int NUM_MICRO  = 16,
  parameter int CWP_WR_W   = $clog2(NWIN) + 2,
  localparam int WIN_W     = $clog2(NWIN),
  localparam int GL_W      = (NUM_GL > 1) ? $clog2(NUM_GL) : 1,
  localparam int TG        = GLOB * NUM_GL,
  localparam int TW        = NWIN * RPW,
  localparam int WIN_SLOTS = RPW + RPW / 2,
  localparam int MB        = GLOB + WIN_SLOTS,
  localparam int ARCH_W    = $clog2(MB + NUM_MICRO),
  localparam int PHYS_W    = $clog2(TG + TW + NUM_MICRO)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cwp_we,
  input  logic [CWP_WR_W-1:0] cwp_wdata,
  input  logic                gl_we,
  input  logic [GL_W-1:0]     gl_wdata,
  input  logic [ARCH_W-1:0]   arch_idx,
  input  logic [1:0]          view_sel,
  output logic [PHYS_W-1:0]   phys_idx
);

  localparam int SLOT_W = $clog2(WIN_SLOTS);
  localparam int OFF_W  = $clog2(TW);
  localparam int G_W    = $clog2(GLOB);

  logic [WIN_W-1:0] cwp_q;
  logic [GL_W-1:0]  gl_q;

  rwt_state #(
    .NWIN(NWIN), .NUM_GL(NUM_GL), .CWP_WR_W(CWP_WR_W)
  ) u_state (
    .clk(clk), .rst(rst),
    .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
    .gl_we(gl_we), .gl_wdata(gl_wdata),
    .cwp_q(cwp_q), .gl_q(gl_q)
  );

  // Classify the architectural number.
  kind_e             kind;
  logic [SLOT_W-1:0] win_slot;
  logic [G_W-1:0]    gslot;

  always_comb begin
    gslot    = arch_idx[G_W-1:0];
    win_slot = SLOT_W'(arch_idx - ARCH_W'(GLOB));
    if (int'(arch_idx) < GLOB)                 kind = KIND_GLOB;
    else if (int'(arch_idx) < MB)              kind = KIND_WIN;
    else if (int'(arch_idx) < MB + NUM_MICRO)  kind = KIND_MICRO;
    else                                       kind = KIND_BAD;
  end

  // Globals, shared by all views.
  logic [PHYS_W-1:0] glob_phys;

  rwt_glob_map #(
    .GLOB(GLOB), .NUM_GL(NUM_GL), .PHYS_W(PHYS_W)
  ) u_glob (
    .gl(gl_q), .gslot(gslot), .phys(glob_phys)
  );

  // One window mapper per view; adjacent windows wrap modulo NWIN.
  logic [WIN_W-1:0] view_win [NUM_VIEWS];
  logic [OFF_W-1:0] view_off [NUM_VIEWS];

  assign view_win[0] = cwp_q;
  assign view_win[1] = cwp_q - WIN_W'(1);
  assign view_win[2] = cwp_q + WIN_W'(1);

  for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
    rwt_win_map #(
      .NWIN(NWIN), .RPW(RPW)
    ) u_win (
      .win(view_win[v]), .slot(win_slot), .offset(view_off[v])
    );
  end

  logic [OFF_W-1:0] sel_off;

  always_comb begin
    case (view_e'(view_sel))
      VIEW_NEXT: sel_off = view_off[1];
      VIEW_PREV: sel_off = view_off[2];
      default:   sel_off = view_off[0];
    endcase
  end

  logic [PHYS_W-1:0] phys_d;

  always_comb begin
    case (kind)
      KIND_GLOB:  phys_d = glob_phys;
      KIND_WIN:   phys_d = PHYS_W'(TG) + PHYS_W'(sel_off);
      KIND_MICRO: phys_d = PHYS_W'(arch_idx) - PHYS_W'(MB) + PHYS_W'(TG + TW);
      default:    phys_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phys_idx <= '0;
    else     phys_idx <= phys_d;
  end

endmodule

// File: rtl/rwt_translator_chk.sv
module rwt_translator_chk #(
  parameter int NWIN       = 8,
  parameter int RPW        = 16,
  parameter int GLOB       = 8,
  parameter int NUM_GL     = 4,
  parameter int NUM_MICRO  = 16,
  parameter int CWP_WR_W   = $clog2(NWIN) + 2,
  localparam int WIN_W     = $clog2(NWIN),
  localparam int GL_W      = (NUM_GL > 1) ? $clog2(NUM_GL) : 1,
  localparam int TG        = GLOB * NUM_GL,
  localparam int TW        = NWIN * RPW,
  localparam int MB        = GLOB + RPW + RPW / 2,
  localparam int ARCH_W    = $clog2(MB + NUM_MICRO),
  localparam int PHYS_W    = $clog2(TG + TW + NUM_MICRO)
) (
  input logic                clk,
  input logic                rst,
  input logic                cwp_we,
  input logic [CWP_WR_W-1:0] cwp_wdata,
  input logic                gl_we,
  input logic [GL_W-1:0]     gl_wdata,
  input logic [ARCH_W-1:0]   arch_idx,
  input logic [1:0]          view_sel,
  input logic [PHYS_W-1:0]   phys_idx,
  input logic [WIN_W-1:0]    cwp_q,
  input logic [GL_W-1:0]     gl_q
);

  logic is_win;
  assign is_win = (int'(arch_idx) >= GLOB) && (int'(arch_idx) < MB);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cwp_q == '0 && gl_q == '0 && phys_idx == '0));

  assert_zero_slot_R2: assert property (@(posedge clk) disable iff (rst)
    arch_idx == '0 |=> phys_idx == '0);

  assert_glob_bank_R3: assert property (@(posedge clk) disable iff (rst)
    (arch_idx != '0 && int'(arch_idx) < GLOB) |=>
      int'(phys_idx) == int'($past(arch_idx)) + int'($past(gl_q)) * GLOB);

  assert_win_current_R4: assert property (@(posedge clk) disable iff (rst)
    (is_win && view_sel == 2'd0) |=>
      int'(phys_idx) == TG + (((int'($past(arch_idx)) - GLOB)
                               - int'($past(cwp_q)) * RPW) % TW + TW) % TW);

  assert_win_next_R5: assert property (@(posedge clk) disable iff (rst)
    (is_win && view_sel == 2'd1) |=>
      int'(phys_idx) == TG + (((int'($past(arch_idx)) - GLOB)
                               - ((int'($past(cwp_q)) + NWIN - 1) % NWIN) * RPW) % TW + TW) % TW);

  assert_cwp_clamp_R6: assert property (@(posedge clk) disable iff (rst)
    (cwp_we && int'(cwp_wdata) >= NWIN) |=> int'(cwp_q) == NWIN - 1);

  assert_cwp_store_R6: assert property (@(posedge clk) disable iff (rst)
    (cwp_we && int'(cwp_wdata) < NWIN) |=> int'(cwp_q) == int'($past(cwp_wdata)));

  assert_gl_store_R7: assert property (@(posedge clk) disable iff (rst)
    gl_we |=> gl_q == $past(gl_wdata));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!cwp_we && !gl_we) |=> ($stable(cwp_q) && $stable(gl_q)));

  assert_micro_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(arch_idx) >= MB && int'(arch_idx) < MB + NUM_MICRO) |=>
      int'(phys_idx) == int'($past(arch_idx)) - MB + TG + TW);

  assert_bad_R9: assert property (@(posedge clk) disable iff (rst)
    (int'(arch_idx) >= MB + NUM_MICRO) |=> phys_idx == '0);

endmodule

bind rwt_translator rwt_translator_chk #(
  .NWIN(NWIN), .RPW(RPW), .GLOB(GLOB), .NUM_GL(NUM_GL),
  .NUM_MICRO(NUM_MICRO), .CWP_WR_W(CWP_WR_W)
) u_chk (
  .clk(clk), .rst(rst), .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
  .gl_we(gl_we), .gl_wdata(gl_wdata), .arch_idx(arch_idx),
  .view_sel(view_sel), .phys_idx(phys_idx), .cwp_q(cwp_q), .gl_q(gl_q)
);

// File: tb/sim_rwt_translator.sv
module sim_rwt_translator;

  localparam int NWIN      = 4;
  localparam int RPW       = 16;
  localparam int GLOB      = 8;
  localparam int NUM_GL    = 2;
  localparam int NUM_MICRO = 4;
  localparam int CWP_WR_W  = 4;
  localparam int GL_W      = 1;
  localparam int TG        = GLOB * NUM_GL;
  localparam int TW        = NWIN * RPW;
  localparam int MB        = GLOB + RPW + RPW / 2;
  localparam int ARCH_W    = $clog2(MB + NUM_MICRO);
  localparam int PHYS_W    = $clog2(TG + TW + NUM_MICRO);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                cwp_we = 1'b0;
  logic [CWP_WR_W-1:0] cwp_wdata = '0;
  logic                gl_we = 1'b0;
  logic [GL_W-1:0]     gl_wdata = '0;
  logic [ARCH_W-1:0]   arch_idx = '0;
  logic [1:0]          view_sel = '0;
  logic [PHYS_W-1:0]   phys_idx;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  rwt_translator #(
    .NWIN(NWIN), .RPW(RPW), .GLOB(GLOB), .NUM_GL(NUM_GL),
    .NUM_MICRO(NUM_MICRO), .CWP_WR_W(CWP_WR_W)
  ) u0 (
    .clk(clk), .rst(rst), .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
    .gl_we(gl_we), .gl_wdata(gl_wdata), .arch_idx(arch_idx),
    .view_sel(view_sel), .phys_idx(phys_idx)
  );

  function automatic int model(int a, int v, int p, int g);
    int w;
    if (a == 0) return 0;
    if (a < GLOB) return a + g * GLOB;
    if (a < MB) begin
      if (v == 1)      w = (p + NWIN - 1) % NWIN;
      else if (v == 2) w = (p + 1) % NWIN;
      else             w = p;
      return TG + (((a - GLOB) - w * RPW) % TW + TW) % TW;
    end
    if (a < MB + NUM_MICRO) return a - MB + TG + TW;
    return 0;
  endfunction

  function automatic string tag_of(int a, int v, int wv, int g);
    if (a == 0) return "R2";
    if (a < GLOB) return (g != 0) ? "R7" : "R3";
    if (a < MB) begin
      if (wv >= NWIN) return "R6";
      return (v == 0) ? "R4" : "R5";
    end
    if (a < MB + NUM_MICRO) return "R8";
    return "R9";
  endfunction

  task automatic chk(string tag, int act, int exp, string ctx);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, ctx, act, exp);
    end
  endtask

  task automatic do_write(int wv, int g);
    @(negedge clk);
    cwp_we = 1'b1; cwp_wdata = CWP_WR_W'(wv);
    gl_we  = 1'b1; gl_wdata  = GL_W'(g);
    @(negedge clk);
    cwp_we = 1'b0; gl_we = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    arch_idx = ARCH_W'(9);
    @(negedge clk);
    chk("R1", int'(phys_idx), 0, "during reset");
    rst = 1'b0;
    arch_idx = ARCH_W'(GLOB);
    @(negedge clk);
    chk("R1", int'(phys_idx), TG, "window slot 0 after reset");
    arch_idx = ARCH_W'(3);
    @(negedge clk);
    chk("R1", int'(phys_idx), 3, "global 3 after reset");

    // R10: write and lookup in the same cycle use the old pointer
    cwp_we = 1'b1; cwp_wdata = CWP_WR_W'(2);
    arch_idx = ARCH_W'(GLOB); view_sel = 2'd0;
    @(negedge clk);
    cwp_we = 1'b0;
    chk("R10", int'(phys_idx), model(GLOB, 0, 0, 0), "same-cycle write");
    @(negedge clk);
    chk("R10", int'(phys_idx), model(GLOB, 0, 2, 0), "cycle after write");
    // R10: back-to-back lookups, one result per cycle
    arch_idx = ARCH_W'(1);
    @(negedge clk);
    chk("R10", int'(phys_idx), 1, "pipelined lookup a");
    arch_idx = ARCH_W'(MB);
    @(negedge clk);
    chk("R10", int'(phys_idx), TG + TW, "pipelined lookup b");

    // R7: no write keeps pointer and level
    gl_we = 1'b1; gl_wdata = 1'b1;
    @(negedge clk);
    gl_we = 1'b0;
    repeat (3) @(negedge clk);
    arch_idx = ARCH_W'(GLOB + 1); view_sel = 2'd0;
    @(negedge clk);
    chk("R7", int'(phys_idx), model(GLOB + 1, 0, 2, 1), "pointer held");
    arch_idx = ARCH_W'(5);
    @(negedge clk);
    chk("R7", int'(phys_idx), model(5, 0, 2, 1), "level held");

    // Full sweep: every write value, level, view and architectural code
    for (int g = 0; g < NUM_GL; g++) begin
      for (int wv = 0; wv < (1 << CWP_WR_W); wv++) begin
        do_write(wv, g);
        for (int v = 0; v < 4; v++) begin
          for (int a = 0; a < (1 << ARCH_W); a++) begin
            int p;
            p = (wv >= NWIN) ? NWIN - 1 : wv;
            arch_idx = ARCH_W'(a); view_sel = 2'(v);
            @(negedge clk);
            chk(tag_of(a, v, wv, g), int'(phys_idx), model(a, v, p, g),
                $sformatf("arch=%0d view=%0d wr=%0d gl=%0d", a, v, wv, g));
          end
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule